// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register port of a classic eight-line priority interrupt controller. Software reaches it through two addresses, selected by one address bit. Address 0 carries two kinds of bytes. One starts the initialization sequence. The other is an operation command, which covers end-of-interrupt, rotation, readback selection, polling and special masking. Address 1 carries the mask, or the next initialization word while a sequence is in progress.

The decoder holds the configuration state that a separate resolver core consumes. That state is the mask, the vector base, the priority base and the mode flags. It also issues one-cycle in-service clear requests to the core. The core returns its in-service and request registers and a poll result, and the decoder multiplexes these onto the read data.

Top module: `intc_cmd_port`

## Requirements
- R1: A write to address 0 with data bit 4 set starts initialization. On the next cycle, maskOut, vecBase and prioBase are 0, specialMask, autoEoi, rotateAeoi and nestedMode are 0, readback selects the request register, and any pending poll is dropped. isrClr pulses all ones for one cycle. Data bit 0 is latched as "mode word expected" and data bit 1 as singleMode.
- R2: If that initialization byte also has bit 3 set, levelErr pulses high for exactly one cycle.
- R3: Address 1 writes follow the initialization step. The first write after start loads vecBase with data bits 7:3 and forces its low three bits to 0. The next step is the cascade step when singleMode is 0, otherwise the mode step when a mode word is expected, otherwise idle. The cascade step ignores its data and moves to the mode step or to idle on the same flag. The mode step loads nestedMode from bit 4 and autoEoi from bit 1, then returns to idle. In idle, an address 1 write loads maskOut.
- R4: An address 0 byte with bit 4 clear and bit 3 set is a read/poll command. If bit 1 is set, bit 0 picks the readback register (1 = in-service, 0 = request). If bit 6 is set, specialMask takes bit 5. If bit 2 is set, poll becomes pending.
- R5: With no poll pending, a read at address 1 returns maskOut. A read at address 0 returns inSvc or reqPend, according to the readback selection.
- R6: While poll is pending, a read at either address returns pollVal and asserts pollAck in that cycle. The pending flag clears after that one read.
- R7: Other address 0 bytes are operation commands, with code = data bits 7:5. Codes 0 and 4 set rotateAeoi to data bit 7. Code 2 changes nothing.
- R8: Codes 1 and 5 request a clear of the highest-priority in-service line. The scan starts at line prioBase and goes upward modulo 8. Code 5 also sets prioBase to that line + 1 modulo 8.
- R9: Code 3 requests a clear of line data[2:0]. Code 7 does the same and also sets prioBase to data[2:0] + 1 modulo 8.
- R10: Code 6 sets prioBase to data[2:0] + 1 modulo 8 and issues no clear.
- R11: An end-of-interrupt code (1, 3, 5 or 7) written while inSvc is all zero issues no clear and leaves prioBase unchanged.
- R12: isrClr is zero in any cycle that does not follow a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrSel | input | 1 | Register address bit (0 or 1) |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data (combinational) |
| inSvc | input | 8 | In-service register from the core |
| reqPend | input | 8 | Request register from the core |
| pollVal | input | 8 | Poll result byte from the core |
| maskOut | output | 8 | Line mask |
| vecBase | output | 8 | Vector base, low three bits zero |
| prioBase | output | 3 | Line holding the highest priority |
| specialMask | output | 1 | Special mask mode |
| autoEoi | output | 1 | Automatic end-of-interrupt mode |
| rotateAeoi | output | 1 | Rotate on automatic end-of-interrupt |
| nestedMode | output | 1 | Special fully nested mode |
| singleMode | output | 1 | No cascade partner |
| isrClr | output | 8 | One-cycle in-service clear request per line |
| levelErr | output | 1 | Unsupported level mode was requested |
| pollAck | output | 1 | Poll read consumed this cycle |

## Verification
The initialization sequence is run with three flag combinations: single with mode word, cascaded with mode word, and single without. Together they show that every step transition is taken and that the cascade word is ignored. End-of-interrupt commands use a two-line in-service pattern under different priority bases. This separates scanning from the base from scanning from line 0. A run with an empty in-service register separates the guarded commands from unguarded ones. Poll reads at both addresses, each followed by a plain read, show that the flag is consumed exactly once.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;

  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_BASE = 2'd1,
    STEP_CASC = 2'd2,
    STEP_MODE = 2'd3
  } initStep_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic initStart;
    logic levelReq;
    logic ldMask;
    logic ldBase;
    logic ldMode;
    logic selLoad;
    logic smmLoad;
    logic pollSet;
    logic ldRotate;
    logic eoiHigh;
    logic eoiLine;
    logic prioFromEoi;
    logic prioSet;
    logic pollRead;
  } cmdStrobe_t;

endpackage

// File: rtl/intc_cmd_ctrl.sv
module intc_cmd_ctrl
  import intc_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              pollPending,
  output cmdStrobe_t        strobe,
  output logic              singleMode
);

  localparam int CODE_LSB = DATA_W - 3;

  initStep_e step, stepNext;
  logic      modeWordExp;
  logic [2:0] opCode;

  assign opCode = wrData[DATA_W-1:CODE_LSB];

  always_comb begin
    strobe   = '0;
    stepNext = step;
    if (wrEn && !addrSel) begin
      if (wrData[4]) begin
        strobe.initStart = 1'b1;
        strobe.levelReq  = wrData[3];
        stepNext         = STEP_BASE;
      end else if (wrData[3]) begin
        strobe.selLoad = wrData[1];
        strobe.smmLoad = wrData[6];
        strobe.pollSet = wrData[2];
      end else begin
        unique case (opCode)
          3'd0, 3'd4: strobe.ldRotate = 1'b1;
          3'd1:       strobe.eoiHigh  = 1'b1;
          3'd5: begin
            strobe.eoiHigh     = 1'b1;
            strobe.prioFromEoi = 1'b1;
          end
          3'd3:       strobe.eoiLine  = 1'b1;
          3'd7: begin
            strobe.eoiLine     = 1'b1;
            strobe.prioFromEoi = 1'b1;
          end
          3'd6:       strobe.prioSet  = 1'b1;
          default: ;
        endcase
      end
    end else if (wrEn && addrSel) begin
      unique case (step)
        STEP_IDLE: strobe.ldMask = 1'b1;
        STEP_BASE: begin
          strobe.ldBase = 1'b1;
          if (!singleMode)      stepNext = STEP_CASC;
          else if (modeWordExp) stepNext = STEP_MODE;
          else                  stepNext = STEP_IDLE;
        end
        STEP_CASC: stepNext = modeWordExp ? STEP_MODE : STEP_IDLE;
        STEP_MODE: begin
          strobe.ldMode = 1'b1;
          stepNext      = STEP_IDLE;
        end
        default: stepNext = STEP_IDLE;
      endcase
    end
    strobe.pollRead = rdEn && pollPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step        <= STEP_IDLE;
      modeWordExp <= 1'b0;
      singleMode  <= 1'b0;
    end else begin
      step <= stepNext;
      if (strobe.initStart) begin
        modeWordExp <= wrData[0];
        singleMode  <= wrData[1];
      end
    end
  end

endmodule

// File: rtl/intc_cmd_regs.sv
module intc_cmd_regs
  import intc_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmdStrobe_t           strobe,
  input  logic                 addrSel,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [NUM_LINES-1:0] inSvc,
  input  logic [NUM_LINES-1:0] reqPend,
  input  logic [NUM_LINES-1:0] pollVal,
  output logic [NUM_LINES-1:0] rdData,
  output logic                 pollPending,
  output logic [NUM_LINES-1:0] maskOut,
  output logic [NUM_LINES-1:0] vecBase,
  output logic [$clog2(NUM_LINES)-1:0] prioBase,
  output logic                 specialMask,
  output logic                 autoEoi,
  output logic                 rotateAeoi,
  output logic                 nestedMode,
  output logic [NUM_LINES-1:0] isrClr,
  output logic                 levelErr
);

  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int BASE_LSB = LINE_W;

  logic              readSelIsr;
  logic              hiFound;
  logic [LINE_W-1:0] hiLine;
  logic [LINE_W-1:0] cmdLine;
  logic              anySvc;

  assign cmdLine = wrData[LINE_W-1:0];
  assign anySvc  = |inSvc;

  // rotating scan: lowest offset from prioBase wins
  always_comb begin
    hiFound = 1'b0;
    hiLine  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      logic [LINE_W-1:0] idx;
      idx = prioBase + LINE_W'(i);
      if (inSvc[idx]) begin
        hiFound = 1'b1;
        hiLine  = idx;
      end
    end
  end

  always_comb begin
    if (pollPending)     rdData = pollVal;
    else if (addrSel)    rdData = maskOut;
    else if (readSelIsr) rdData = inSvc;
    else                 rdData = reqPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskOut     <= '0;
      vecBase     <= '0;
      prioBase    <= '0;
      readSelIsr  <= 1'b0;
      pollPending <= 1'b0;
      specialMask <= 1'b0;
      autoEoi     <= 1'b0;
      rotateAeoi  <= 1'b0;
      nestedMode  <= 1'b0;
      isrClr      <= '0;
      levelErr    <= 1'b0;
    end else begin
      isrClr   <= '0;
      levelErr <= 1'b0;
      if (strobe.pollRead) pollPending <= 1'b0;
      if (strobe.initStart) begin
        maskOut     <= '0;
        vecBase     <= '0;
        prioBase    <= '0;
        readSelIsr  <= 1'b0;
        pollPending <= 1'b0;
        specialMask <= 1'b0;
        autoEoi     <= 1'b0;
        rotateAeoi  <= 1'b0;
        nestedMode  <= 1'b0;
        isrClr      <= '1;
        levelErr    <= strobe.levelReq;
      end
      if (strobe.ldMask) maskOut <= wrData;
      if (strobe.ldBase) vecBase <= {wrData[NUM_LINES-1:BASE_LSB], {LINE_W{1'b0}}};
      if (strobe.ldMode) begin
        nestedMode <= wrData[4];
        autoEoi    <= wrData[1];
      end
      if (strobe.selLoad) readSelIsr  <= wrData[0];
      if (strobe.smmLoad) specialMask <= wrData[5];
      if (strobe.pollSet) pollPending <= 1'b1;
      if (strobe.ldRotate) rotateAeoi <= wrData[NUM_LINES-1];
      if (strobe.eoiHigh && hiFound) begin
        isrClr <= NUM_LINES'(1) << hiLine;
        if (strobe.prioFromEoi) prioBase <= hiLine + 1'b1;
      end
      if (strobe.eoiLine && anySvc) begin
        isrClr <= NUM_LINES'(1) << cmdLine;
        if (strobe.prioFromEoi) prioBase <= cmdLine + 1'b1;
      end
      if (strobe.prioSet) prioBase <= cmdLine + 1'b1;
    end
  end

endmodule

// File: rtl/intc_cmd_port.sv
module intc_cmd_port
  import intc_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addrSel,
  input  logic                 wrEn,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic                 rdEn,
  output logic [NUM_LINES-1:0] rdData,
  input  logic [NUM_LINES-1:0] inSvc,
  input  logic [NUM_LINES-1:0] reqPend,
  input  logic [NUM_LINES-1:0] pollVal,
  output logic [NUM_LINES-1:0] maskOut,
  output logic [NUM_LINES-1:0] vecBase,
  output logic [$clog2(NUM_LINES)-1:0] prioBase,
  output logic                 specialMask,
  output logic                 autoEoi,
  output logic                 rotateAeoi,
  output logic                 nestedMode,
  output logic                 singleMode,
  output logic [NUM_LINES-1:0] isrClr,
  output logic                 levelErr,
  output logic                 pollAck
);

  cmdStrobe_t strobe;
  logic       pollPending;

  intc_cmd_ctrl #(.DATA_W(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .pollPending(pollPending), .strobe(strobe), .singleMode(singleMode)
  );

  intc_cmd_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrSel(addrSel), .wrData(wrData),
    .inSvc(inSvc), .reqPend(reqPend), .pollVal(pollVal), .rdData(rdData),
    .pollPending(pollPending), .maskOut(maskOut), .vecBase(vecBase),
    .prioBase(prioBase), .specialMask(specialMask), .autoEoi(autoEoi),
    .rotateAeoi(rotateAeoi), .nestedMode(nestedMode), .isrClr(isrClr),
    .levelErr(levelErr)
  );

  assign pollAck = strobe.pollRead;

endmodule

// File: rtl/intc_cmd_checker.sv
module intc_cmd_checker #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 addrSel,
  input logic                 wrEn,
  input logic [NUM_LINES-1:0] wrData,
  input logic                 rdEn,
  input logic [NUM_LINES-1:0] inSvc,
  input logic [NUM_LINES-1:0] maskOut,
  input logic [NUM_LINES-1:0] vecBase,
  input logic [$clog2(NUM_LINES)-1:0] prioBase,
  input logic [NUM_LINES-1:0] isrClr,
  input logic                 levelErr,
  input logic                 pollAck
);

  localparam int LINE_W = $clog2(NUM_LINES);

  assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addrSel && wrData[4]) |=> (maskOut == '0 && prioBase == '0 && isrClr == '1));

  assert_level_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    levelErr |-> $past(wrEn && !addrSel && wrData[4] && wrData[3]));

  assert_base_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    vecBase[LINE_W-1:0] == '0);

  assert_poll_on_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    pollAck |-> rdEn);

  assert_poll_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pollAck && !wrEn) |=> !pollAck);

  assert_empty_eoi_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addrSel && wrData[4:3] == 2'b00 && wrData[5] && inSvc == '0)
      |=> (isrClr == '0 && $stable(prioBase)));

  assert_clr_after_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> isrClr == '0);

endmodule

bind intc_cmd_port intc_cmd_checker #(.NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/test_intc_cmd_port.sv
module test_intc_cmd_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0, inSvc = '0, reqPend = '0, pollVal = '0;
  logic [7:0] rdData, maskOut, vecBase, isrClr;
  logic [2:0] prioBase;
  logic       specialMask, autoEoi, rotateAeoi, nestedMode, singleMode, levelErr, pollAck;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int mMask, mBase, mPrio, mSel, mPoll, mSmm, mAeoi, mRot, mNest, mSingle, mFourth, mStep;
  int eClr, eLvl;

  always #2 clk = ~clk;

  intc_cmd_port i_intc_cmd_port (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .inSvc(inSvc), .reqPend(reqPend), .pollVal(pollVal),
    .maskOut(maskOut), .vecBase(vecBase), .prioBase(prioBase), .specialMask(specialMask),
    .autoEoi(autoEoi), .rotateAeoi(rotateAeoi), .nestedMode(nestedMode),
    .singleMode(singleMode), .isrClr(isrClr), .levelErr(levelErr), .pollAck(pollAck)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R3 maskOut", maskOut, mMask);
    check("R3 vecBase", vecBase, mBase);
    check("R8 prioBase", prioBase, mPrio);
    check("R4 specialMask", specialMask, mSmm);
    check("R3 autoEoi", autoEoi, mAeoi);
    check("R7 rotateAeoi", rotateAeoi, mRot);
    check("R3 nestedMode", nestedMode, mNest);
    check("R1 singleMode", singleMode, mSingle);
    check("R12 isrClr", isrClr, eClr);
    check("R2 levelErr", levelErr, eLvl);
  endtask

  function automatic int highLine();
    for (int i = 0; i < 8; i++) begin
      int idx = (mPrio + i) % 8;
      if (inSvc[idx]) return idx;
    end
    return -1;
  endfunction

  function automatic void modelWrite(int a, int d);
    int code, line, hi;
    eClr = 0; eLvl = 0;
    if (a == 0) begin
      if (d & 8'h10) begin
        mMask = 0; mBase = 0; mPrio = 0; mSel = 0; mPoll = 0; mSmm = 0;
        mAeoi = 0; mRot = 0; mNest = 0; eClr = 8'hFF;
        eLvl = (d >> 3) & 1; mFourth = d & 1; mSingle = (d >> 1) & 1; mStep = 1;
      end else if (d & 8'h08) begin
        if (d & 2) mSel = d & 1;
        if (d & 8'h40) mSmm = (d >> 5) & 1;
        if (d & 4) mPoll = 1;
      end else begin
        code = (d >> 5) & 7; line = d & 7; hi = highLine();
        case (code)
          0, 4: mRot = (d >> 7) & 1;
          1, 5: if (hi >= 0) begin
            eClr = 1 << hi;
            if (code == 5) mPrio = (hi + 1) % 8;
          end
          3, 7: if (inSvc != 0) begin
            eClr = 1 << line;
            if (code == 7) mPrio = (line + 1) % 8;
          end
          6: mPrio = (line + 1) % 8;
          default: ;
        endcase
      end
    end else begin
      case (mStep)
        0: mMask = d;
        1: begin
          mBase = d & 8'hF8;
          mStep = !mSingle ? 2 : (mFourth ? 3 : 0);
        end
        2: mStep = mFourth ? 3 : 0;
        default: begin
          mNest = (d >> 4) & 1; mAeoi = (d >> 1) & 1; mStep = 0;
        end
      endcase
    end
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    addrSel = a[0]; wrData = d[7:0]; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
    #1 compareAll();
  endtask

  task automatic rd(int a, string tag);
    int exp;
    @(negedge clk);
    addrSel = a[0]; rdEn = 1'b1;
    #1;
    exp = mPoll ? pollVal : (a != 0 ? mMask : (mSel != 0 ? inSvc : reqPend));
    check({tag, " rdData"}, rdData, exp);
    check({tag, " pollAck"}, pollAck, mPoll);
    @(negedge clk);
    rdEn = 1'b0;
    mPoll = 0; eClr = 0; eLvl = 0;
    #1 compareAll();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mMask = 0; mBase = 0; mPrio = 0; mSel = 0; mPoll = 0; mSmm = 0; mAeoi = 0;
    mRot = 0; mNest = 0; mSingle = 0; mFourth = 0; mStep = 0; eClr = 0; eLvl = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 compareAll();                 // R1 reset state
    reqPend = 8'h5A; inSvc = 8'h24; pollVal = 8'h83;

    // R3 single + mode word
    wr(0, 8'h13); wr(1, 8'h45); wr(1, 8'h12); wr(1, 8'hA5);
    rd(1, "R5 mask read");
    rd(0, "R5 request read");
    // R3 cascaded + mode word
    wr(0, 8'h11); wr(1, 8'h27); wr(1, 8'hFF); wr(1, 8'h02); wr(1, 8'h3C);
    // R3 single without mode word, R2 level flag
    wr(0, 8'h12); wr(1, 8'hF9); wr(1, 8'h81);
    wr(0, 8'h1A); wr(1, 8'h08); wr(1, 8'h00);
    wr(1, 8'h3C);

    // R4 readback and special mask
    wr(0, 8'h0B); rd(0, "R5 isr read");
    wr(0, 8'h0A); rd(0, "R5 irr read");
    wr(0, 8'h68); wr(0, 8'h48);
    // R6 poll at both addresses
    wr(0, 8'h0C); rd(1, "R6 poll addr1"); rd(1, "R6 after poll");
    wr(0, 8'h0C); rd(0, "R6 poll addr0"); rd(0, "R6 after poll");

    // R8 nonspecific with rotation base
    wr(0, 8'h20); wr(0, 8'hA0); wr(0, 8'h20);
    // R9 specific
    wr(0, 8'h65); wr(0, 8'hE6);
    // R10 set base, R7 rotate and no-op
    wr(0, 8'hC7); wr(0, 8'hC3); wr(0, 8'h80); wr(0, 8'h40); wr(0, 8'h00);
    // R11 empty in-service
    inSvc = 8'h00;
    wr(0, 8'h20); wr(0, 8'hA0); wr(0, 8'h67); wr(0, 8'hE1);
    inSvc = 8'h81;
    wr(0, 8'hA0); wr(0, 8'h20);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule